// File: doc/BRIEF.md
# Tick-Driven Watchdog with Software Clear

This block guards a processor against a hung program. A prescaler elsewhere delivers a one-cycle pulse once per second, and the block counts those pulses in a small counter. Software must write a clear command before the counter runs out. If it does not, the block drives a system reset pulse of fixed length to the processor and its peripherals. The counter then restarts from zero.

Software sees a 4-bit register. Bit 3 is the clear command, which is write-only. Bits 2 and 1 show the two counter stages: bit 1 toggles at half the tick rate and bit 2 at a quarter of it. Bit 0 is a general interrupt mask that the block only stores.

The counter keeps running while the system is in standby. An enable tie-off, fixed when the chip is built, can switch off the reset action while leaving the counter running and readable. The timeout runs from three to four ticks after the last clear, depending on the tick phase at the moment of the clear. If the prescaler chain is restarted, ticks can come early, so the real time to reset can shrink to about two seconds.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, `reg_rdata_o` reads 4'b0000 and `sys_rst_o` is low.
- R2: Each cycle with `tick_i` high advances the 2-bit count by one, wrapping from 3 to 0, unless a clear or a reset pulse applies in that cycle.
- R3: Read layout: bit 2 is the count MSB (quarter-rate stage), bit 1 is the count LSB (half-rate stage), bit 0 is the mask, and bit 3 always reads 0.
- R4: A write with bit 3 set makes the count read 0 from the next cycle on.
- R5: Write data in bits 2:1 has no effect, and a write with bit 3 clear leaves the count unchanged.
- R6: Every write stores bit 0 of the write data as the mask, and the mask reads back on bit 0 from the next cycle on.
- R7: A tick while the count is 3, with no clear and with `enable_i` high, raises `sys_rst_o` in the next cycle for exactly RST_CYCLES cycles (default 4).
- R8: While `sys_rst_o` is high, the count is held at 0 and ticks are ignored. The count reads 0 when the pulse ends.
- R9: A clear write in the same cycle as a tick wins: the count becomes 0 and no reset pulse starts, even if the count was 3.
- R10: `standby_i` high does not stop the counting (default RUN_IN_STANDBY=1).
- R11: With `enable_i` low, the count still advances and wraps, but `sys_rst_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse from the 1 Hz prescaler stage |
| standby_i | input | 1 | System standby indication |
| enable_i | input | 1 | Tie-off that enables the reset action |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data |
| sys_rst_o | output | 1 | Active-high system reset pulse |

## Verification
The count stages appear directly on read bits 2:1, so a wrong count shows at the ports in the cycle after the tick or clear that caused it. A counter that is off by one changes when the reset fires: the pulse comes one tick early or late, or a clear that should have prevented it does not. A pulse of the wrong length, or a count not held during the pulse, shows on `sys_rst_o` or on the stage bits within RST_CYCLES cycles.

// File: rtl/tick_wd_pkg.sv
`timescale 1ns/1ps
package tick_wd_pkg;
   // fixed field placement inside the software register
   localparam int unsigned MASK_BIT  = 0;
   localparam int unsigned STAGE_LSB = 1;

   // decoded register write
   typedef struct packed {
      logic clear;
      logic store;
      logic mask_val;
   } wd_cmd_t;
endpackage

// File: rtl/twd_regs.sv
`timescale 1ns/1ps
module twd_regs
   import tick_wd_pkg::*;
#(
   parameter int unsigned STAGE_W = 2,
   localparam int unsigned REG_W  = STAGE_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic               clr_bit_i,
   input  logic               mask_bit_i,
   input  logic [STAGE_W-1:0] stage_i,
   output logic               clear_o,
   output logic [REG_W-1:0]   rdata_o
);
   wd_cmd_t cmd;
   logic    mask_q;

   always_comb begin
      cmd.clear    = wr_i & clr_bit_i;
      cmd.store    = wr_i;
      cmd.mask_val = mask_bit_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= 1'b0;
      else if (cmd.store)
         mask_q <= cmd.mask_val;
   end

   assign clear_o = cmd.clear;

   always_comb begin
      rdata_o                           = '0;
      rdata_o[MASK_BIT]                 = mask_q;
      rdata_o[STAGE_LSB +: STAGE_W]     = stage_i;
      rdata_o[REG_W-1]                  = 1'b0;
   end
endmodule

// File: rtl/twd_count.sv
`timescale 1ns/1ps
module twd_count #(
   parameter int unsigned STAGE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step_i,
   input  logic               clear_i,
   input  logic               hold_i,
   output logic [STAGE_W-1:0] stage_o,
   output logic               wrap_o
);
   localparam logic [STAGE_W-1:0] ONE = STAGE_W'(1);

   logic [STAGE_W-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stage_q <= '0;
      else if (clear_i || hold_i)
         stage_q <= '0;
      else if (step_i)
         stage_q <= stage_q + ONE;
   end

   assign stage_o = stage_q;
   assign wrap_o  = step_i & (&stage_q) & ~clear_i & ~hold_i;
endmodule

// File: rtl/twd_pulse.sv
`timescale 1ns/1ps
module twd_pulse #(
   parameter int unsigned RST_CYCLES = 4,
   localparam int unsigned LEFT_W    = $clog2(RST_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic pulse_o
);
   if (RST_CYCLES == 1) begin : g_single
      logic pulse_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pulse_q <= 1'b0;
         else
            pulse_q <= fire_i;
      end
      assign pulse_o = pulse_q;
   end else begin : g_stretch
      logic [LEFT_W-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            left_q <= '0;
         else if (fire_i)
            left_q <= LEFT_W'(RST_CYCLES);
         else if (left_q != '0)
            left_q <= left_q - 1'b1;
      end
      assign pulse_o = (left_q != '0);
   end
endmodule

// File: rtl/tick_watchdog.sv
`timescale 1ns/1ps
module tick_watchdog
   import tick_wd_pkg::*;
#(
   parameter int unsigned STAGE_W        = 2,
   parameter int unsigned RST_CYCLES     = 4,
   parameter bit          RUN_IN_STANDBY = 1'b1,
   localparam int unsigned REG_W         = STAGE_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             standby_i,
   input  logic             enable_i,
   input  logic             reg_wr_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   output logic [REG_W-1:0] reg_rdata_o,
   output logic             sys_rst_o
);
   if (STAGE_W < 1) begin : g_bad_stage
      $error("tick_watchdog: STAGE_W must be at least 1");
   end
   if (RST_CYCLES < 1) begin : g_bad_len
      $error("tick_watchdog: RST_CYCLES must be at least 1");
   end

   logic               step;
   logic               clear;
   logic               wrap;
   logic               fire;
   logic [STAGE_W-1:0] stage;

   // standby gates the count only in the variant that stops in standby
   assign step = tick_i & ~(standby_i & ~RUN_IN_STANDBY);
   assign fire = wrap & enable_i;

   twd_regs #(.STAGE_W(STAGE_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (reg_wr_i),
      .clr_bit_i (reg_wdata_i[REG_W-1]),
      .mask_bit_i(reg_wdata_i[MASK_BIT]),
      .stage_i   (stage),
      .clear_o   (clear),
      .rdata_o   (reg_rdata_o)
   );

   twd_count #(.STAGE_W(STAGE_W)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step),
      .clear_i(clear),
      .hold_i (sys_rst_o),
      .stage_o(stage),
      .wrap_o (wrap)
   );

   twd_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (fire),
      .pulse_o(sys_rst_o)
   );
endmodule

// File: rtl/twd_checker.sv
`timescale 1ns/1ps
module twd_checker #(
   parameter int unsigned STAGE_W        = 2,
   parameter int unsigned RST_CYCLES     = 4,
   parameter bit          RUN_IN_STANDBY = 1'b1,
   localparam int unsigned REG_W         = STAGE_W + 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             standby_i,
   input logic             enable_i,
   input logic             reg_wr_i,
   input logic [REG_W-1:0] reg_wdata_i,
   input logic [REG_W-1:0] reg_rdata_o,
   input logic             sys_rst_o
);
   logic [STAGE_W-1:0] stg;
   logic               clr;
   logic               stp;
   logic               stage_bits_set;
   int unsigned        hi_cnt;

   assign stg            = reg_rdata_o[STAGE_W:1];
   assign clr            = reg_wr_i & reg_wdata_i[REG_W-1];
   assign stp            = tick_i & (RUN_IN_STANDBY | ~standby_i);
   assign stage_bits_set = |reg_wdata_i[STAGE_W:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_cnt <= 0;
      else if (sys_rst_o)
         hi_cnt <= hi_cnt + 1;
      else
         hi_cnt <= 0;
   end

   // R3
   read_clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata_o[REG_W-1] == 1'b0);

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stp && !clr && !sys_rst_o |=> stg == STAGE_W'($past(stg) + 1'b1));

   // R4
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> stg == '0);

   // R5
   stage_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_i && !clr && stage_bits_set && !stp && !sys_rst_o |=> $stable(stg));

   // R6
   mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_i |=> reg_rdata_o[0] == $past(reg_wdata_i[0]));

   // R7
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> $past(stp && (&stg) && !clr && enable_i));

   // R7
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst_o) |-> hi_cnt == RST_CYCLES);

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |=> stg == '0);

   // R9
   clear_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr && tick_i && !sys_rst_o |=> !sys_rst_o && stg == '0);

   // R11
   disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i && !sys_rst_o |=> !sys_rst_o);
endmodule

bind tick_watchdog twd_checker #(
   .STAGE_W       (STAGE_W),
   .RST_CYCLES    (RST_CYCLES),
   .RUN_IN_STANDBY(RUN_IN_STANDBY)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_i     (tick_i),
   .standby_i  (standby_i),
   .enable_i   (enable_i),
   .reg_wr_i   (reg_wr_i),
   .reg_wdata_i(reg_wdata_i),
   .reg_rdata_o(reg_rdata_o),
   .sys_rst_o  (sys_rst_o)
);

// File: tb/tick_watchdog_tb.sv
`timescale 1ns/1ps
module tick_watchdog_tb;
   localparam int unsigned RST_LEN = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       standby = 1'b0;
   logic       enable = 1'b1;
   logic       wr = 1'b0;
   logic [3:0] wdata = 4'h0;
   logic [3:0] rdata;
   logic       sys_rst;

   int checks = 0;
   int errors = 0;

   // scoreboard: expected {rdata, sys_rst} and the requirement tag
   logic [4:0] exp_q[$];
   string      tag_q[$];

   // reference model state
   logic [1:0] m_cnt = 2'd0;
   logic       m_mask = 1'b0;
   int         m_left = 0;

   always #10 clk = ~clk;

   tick_watchdog #(.RST_CYCLES(RST_LEN)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .standby_i  (standby),
      .enable_i   (enable),
      .reg_wr_i   (wr),
      .reg_wdata_i(wdata),
      .reg_rdata_o(rdata),
      .sys_rst_o  (sys_rst)
   );

   task automatic cyc(input logic t, input logic w, input logic [3:0] d, input string tag);
      logic clr;
      logic hold;
      logic fire;
      @(negedge clk);
      tick  = t;
      wr    = w;
      wdata = d;
      clr  = w & d[3];
      hold = (m_left != 0);
      fire = t && (m_cnt == 2'd3) && !clr && !hold && enable;
      if (clr || hold) m_cnt = 2'd0;
      else if (t)      m_cnt = m_cnt + 2'd1;
      if (w) m_mask = d[0];
      if (fire)             m_left = RST_LEN;
      else if (m_left != 0) m_left = m_left - 1;
      exp_q.push_back({1'b0, m_cnt, m_mask, (m_left != 0)});
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'h0, tag);
   endtask

   // monitor: compares one expected item per clock, away from the edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            logic [4:0] e;
            string      tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if ({rdata, sys_rst} !== e) begin
               errors++;
               $display("FAIL %s: rdata=%b rst=%b expected rdata=%b rst=%b",
                        tg, rdata, sys_rst, e[4:1], e[0]);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      checks++;
      if (rdata !== 4'h0 || sys_rst !== 1'b0) begin
         errors++;
         $display("FAIL R1: rdata=%b rst=%b expected rdata=0000 rst=0", rdata, sys_rst);
      end
      idle(2, "R1");

      // R2 / R3 counting and stage bit placement
      cyc(1, 0, 4'h0, "R2"); idle(1, "R3");
      cyc(1, 0, 4'h0, "R2"); idle(1, "R3");
      cyc(1, 0, 4'h0, "R2"); idle(1, "R3");

      // R4 clear
      cyc(0, 1, 4'b1000, "R4"); idle(1, "R4");

      // R6 mask storage
      cyc(0, 1, 4'b0001, "R6");
      cyc(0, 1, 4'b0000, "R6");
      cyc(0, 1, 4'b0001, "R6"); idle(1, "R6");

      // R5 stage bits not writable, write without clear keeps count
      cyc(1, 0, 4'h0, "R5"); cyc(1, 0, 4'h0, "R5");
      cyc(0, 1, 4'b0110, "R5"); idle(1, "R5");
      cyc(0, 1, 4'b1111, "R5"); idle(1, "R3");

      // R7 / R8 timeout pulse, ticks ignored while it is high
      cyc(1, 0, 4'h0, "R7"); idle(1, "R7");
      cyc(1, 0, 4'h0, "R7"); idle(1, "R7");
      cyc(1, 0, 4'h0, "R7"); idle(1, "R7");
      cyc(1, 0, 4'h0, "R7");
      for (int i = 0; i < RST_LEN; i++) cyc(1, 0, 4'h0, "R8");
      idle(3, "R8");

      // R9 clear and tick together at count 3
      cyc(1, 0, 4'h0, "R9"); cyc(1, 0, 4'h0, "R9"); cyc(1, 0, 4'h0, "R9");
      cyc(1, 1, 4'b1000, "R9");
      idle(RST_LEN + 2, "R9");

      // R10 standby does not stop counting
      standby = 1'b1;
      cyc(1, 0, 4'h0, "R10"); idle(1, "R10");
      cyc(1, 0, 4'h0, "R10"); idle(1, "R10");
      standby = 1'b0;
      cyc(0, 1, 4'b1000, "R4");

      // R11 reset action disabled: count wraps, no pulse
      enable = 1'b0;
      for (int i = 0; i < 5; i++) begin
         cyc(1, 0, 4'h0, "R11");
         idle(1, "R11");
      end
      idle(RST_LEN + 1, "R11");
      enable = 1'b1;
      idle(2, "R2");

      repeat (3) @(posedge clk);
      #6;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule